// File: doc/BRIEF.md
# Parallel Write-Merge Register Unit

This unit commits the register results of one instruction in which a main operation and a packed extension operation run side by side. Both operations read the register file as it stood before the instruction started. The extension's results are not written to the file at once. They are held in a short list of pending (register number, value) entries. The main operation then writes its results directly. At the end of the instruction, a single commit cycle folds the pending entries into the file.

The merge rule is chosen per instruction. In precise merging, every register named in the pending list is cleared after the main operation has read its operands. The main operation then writes, and the commit ORs each pending value into its register. A register that both operations write therefore ends up with the bitwise OR of the two results. In overwrite merging there is no clearing step, and the commit replaces the register with the pending value, so the extension result wins. The register file is a plain array of 16-bit words. Instruction decode belongs to the surrounding core.

A small state machine sequences each instruction. Its states are IDLE, CAPTURE (extension writes are being recorded), CLEAR (pending destinations are zeroed), EXEC (the main operation writes) and COMMIT (the pending list is applied and emptied). Its transitions are start (IDLE→CAPTURE on `begin_i`), operands-done (CAPTURE→CLEAR on `ops_read_i`), clear-done (CLEAR→EXEC, unconditional), finish (EXEC→COMMIT on `end_i`) and retire (COMMIT→IDLE, unconditional).

Top module: `write_merge_unit`

## Requirements
- R1: After reset every register reads 0, the state machine is in IDLE and the pending list is empty.
- R2: An extension write recorded in CAPTURE does not change the register file; a read during CAPTURE returns the value from before the instruction.
- R3: The pending list holds at most DEPTH (4) entries. Extension writes beyond that in the same instruction are dropped and have no effect on the result.
- R4: In precise merging, a register written by both operations ends as (main value OR extension value), whatever it held before.
- R5: In precise merging, a register written only by the extension ends as exactly the extension value. Its old content is not ORed in.
- R6: In precise merging, every register named in the pending list reads 0 during the EXEC state, until the main operation writes it. In overwrite merging it keeps its old value during EXEC.
- R7: In overwrite merging, a register written by both operations ends as the extension value, and a register written only by the extension ends as the extension value.
- R8: When the pending list names one register several times, precise merging ORs all of those values. Overwrite merging keeps the value recorded last.
- R9: A register not named in the pending list keeps its old value, or the main value if the main operation wrote it.
- R10: The merge mode (`precise_i`: 1 = precise, 0 = overwrite) is taken in the IDLE cycle in which `begin_i` is seen. Changes during the instruction have no effect.
- R11: The state machine follows IDLE→CAPTURE→CLEAR→EXEC→COMMIT→IDLE. CLEAR and COMMIT last one cycle each. The pending list is empty after COMMIT. Control pulses outside their own state are ignored. Extension writes outside CAPTURE and main writes outside EXEC are ignored.
- R12: A main write in EXEC goes straight into the register file. A register with no pending entry keeps it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| precise_i | input | 1 | Merge mode for the next instruction: 1 = precise OR merging, 0 = extension overwrites |
| begin_i | input | 1 | Start of an instruction (taken in IDLE) |
| ops_read_i | input | 1 | Main operation has read its operands (taken in CAPTURE) |
| end_i | input | 1 | Main operation has finished writing (taken in EXEC) |
| ext_we_i | input | 1 | Extension write strobe (taken in CAPTURE) |
| ext_idx_i | input | IDX_W | Extension destination register |
| ext_data_i | input | DATA_W | Extension result |
| main_we_i | input | 1 | Main write strobe (taken in EXEC) |
| main_idx_i | input | IDX_W | Main destination register |
| main_data_i | input | DATA_W | Main result |
| rd_idx_i | input | IDX_W | Read port register number |
| rd_data_o | output | DATA_W | Current register contents, combinational |

## Verification
Two things can land on the same register in one instruction: the main operation's direct write and the commit of a pending extension entry. The bench provokes this by sweeping every pairing of extension destination and main destination in both merge modes, so the two destinations are sometimes the same register and sometimes different ones. After the commit it compares every register with a value computed arithmetically from the mode: the OR of the two results, the extension value alone, or the main value alone. Duplicate pending entries, overflow of the pending list and reads taken during CAPTURE and EXEC test the intermediate steps of the same collision.

// File: rtl/wmb_pkg.sv
package wmb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CAPTURE = 3'd1,
        ST_CLEAR   = 3'd2,
        ST_EXEC    = 3'd3,
        ST_COMMIT  = 3'd4
    } wmb_state_e;

endpackage

// File: rtl/wmb_ctrl.sv
module wmb_ctrl
    import wmb_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       begin_i,
    input  logic       ops_read_i,
    input  logic       end_i,
    input  logic       precise_i,
    output wmb_state_e state_o,
    output logic       merge_or_o,
    output logic       cap_en_o,
    output logic       clr_en_o,
    output logic       exec_en_o,
    output logic       commit_en_o
);

    wmb_state_e state_q, state_d;
    logic       precise_q;

    // state register and latched merge mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            precise_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && begin_i) begin
                precise_q <= precise_i;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (begin_i)    state_d = ST_CAPTURE;
            ST_CAPTURE: if (ops_read_i) state_d = ST_CLEAR;
            ST_CLEAR:                   state_d = ST_EXEC;
            ST_EXEC:    if (end_i)      state_d = ST_COMMIT;
            ST_COMMIT:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cap_en_o    = 1'b0;
        clr_en_o    = 1'b0;
        exec_en_o   = 1'b0;
        commit_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CAPTURE: cap_en_o    = 1'b1;
            ST_CLEAR:   clr_en_o    = precise_q;
            ST_EXEC:    exec_en_o   = 1'b1;
            ST_COMMIT:  commit_en_o = 1'b1;
            default:    ;
        endcase
    end

    assign state_o    = state_q;
    assign merge_or_o = precise_q;

endmodule

// File: rtl/wmb_backlog.sv
module wmb_backlog #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 3
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           cap_en_i,
    input  logic                           we_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [DATA_W-1:0]              data_i,
    input  logic                           flush_i,
    output logic [NREG-1:0]                pend_o,
    output logic [NREG-1:0][DATA_W-1:0]    or_val_o,
    output logic [NREG-1:0][DATA_W-1:0]    last_val_o,
    output logic [CNT_W-1:0]               cnt_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [DEPTH-1:0]  vld_q;
    logic [IDX_W-1:0]  idx_q [DEPTH];
    logic [DATA_W-1:0] dat_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic              push;

    assign push = cap_en_i && we_i && (cnt_q != FULL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vld_q <= '0;
            cnt_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                idx_q[k] <= '0;
                dat_q[k] <= '0;
            end
        end else if (flush_i) begin
            vld_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            cnt_q <= cnt_q + 1'b1;
            for (int k = 0; k < DEPTH; k++) begin
                if (cnt_q == CNT_W'(k)) begin
                    vld_q[k] <= 1'b1;
                    idx_q[k] <= idx_i;
                    dat_q[k] <= data_i;
                end
            end
        end
    end

    // per-register view of the pending list, walked in recording order
    for (genvar r = 0; r < NREG; r++) begin : g_view
        logic              hit;
        logic [DATA_W-1:0] acc_or;
        logic [DATA_W-1:0] acc_last;

        always_comb begin
            hit      = 1'b0;
            acc_or   = '0;
            acc_last = '0;
            for (int k = 0; k < DEPTH; k++) begin
                if (vld_q[k] && idx_q[k] == IDX_W'(r)) begin
                    hit      = 1'b1;
                    acc_or   = acc_or | dat_q[k];
                    acc_last = dat_q[k];
                end
            end
        end

        assign pend_o[r]     = hit;
        assign or_val_o[r]   = acc_or;
        assign last_val_o[r] = acc_last;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wmb_regfile.sv
module wmb_regfile #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        clr_en_i,
    input  logic                        exec_en_i,
    input  logic                        commit_en_i,
    input  logic                        merge_or_i,
    input  logic [NREG-1:0]             pend_i,
    input  logic [NREG-1:0][DATA_W-1:0] or_val_i,
    input  logic [NREG-1:0][DATA_W-1:0] last_val_i,
    input  logic                        main_we_i,
    input  logic [IDX_W-1:0]            main_idx_i,
    input  logic [DATA_W-1:0]           main_data_i,
    input  logic [IDX_W-1:0]            rd_idx_i,
    output logic [DATA_W-1:0]           rd_data_o
);

    logic [DATA_W-1:0] word [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [DATA_W-1:0] q;
        logic              main_hit;

        assign main_hit = exec_en_i && main_we_i && (main_idx_i == IDX_W'(r));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                q <= '0;
            end else if (clr_en_i && pend_i[r]) begin
                q <= '0;
            end else if (main_hit) begin
                q <= main_data_i;
            end else if (commit_en_i && pend_i[r]) begin
                q <= merge_or_i ? (q | or_val_i[r]) : last_val_i[r];
            end
        end

        assign word[r] = q;
    end

    always_comb begin
        rd_data_o = '0;
        for (int r = 0; r < NREG; r++) begin
            if (rd_idx_i == IDX_W'(r)) begin
                rd_data_o = word[r];
            end
        end
    end

endmodule

// File: rtl/write_merge_unit.sv
module write_merge_unit
    import wmb_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              precise_i,
    input  logic              begin_i,
    input  logic              ops_read_i,
    input  logic              end_i,
    input  logic              ext_we_i,
    input  logic [IDX_W-1:0]  ext_idx_i,
    input  logic [DATA_W-1:0] ext_data_i,
    input  logic              main_we_i,
    input  logic [IDX_W-1:0]  main_idx_i,
    input  logic [DATA_W-1:0] main_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    wmb_state_e                  state_w;
    logic                        merge_or_w;
    logic                        cap_en_w;
    logic                        clr_en_w;
    logic                        exec_en_w;
    logic                        commit_en_w;
    logic [NREG-1:0]             pend_w;
    logic [NREG-1:0][DATA_W-1:0] or_val_w;
    logic [NREG-1:0][DATA_W-1:0] last_val_w;
    logic [CNT_W-1:0]            cnt_w;

    wmb_ctrl u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .begin_i     (begin_i),
        .ops_read_i  (ops_read_i),
        .end_i       (end_i),
        .precise_i   (precise_i),
        .state_o     (state_w),
        .merge_or_o  (merge_or_w),
        .cap_en_o    (cap_en_w),
        .clr_en_o    (clr_en_w),
        .exec_en_o   (exec_en_w),
        .commit_en_o (commit_en_w)
    );

    wmb_backlog #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_backlog (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_en_i   (cap_en_w),
        .we_i       (ext_we_i),
        .idx_i      (ext_idx_i),
        .data_i     (ext_data_i),
        .flush_i    (commit_en_w),
        .pend_o     (pend_w),
        .or_val_o   (or_val_w),
        .last_val_o (last_val_w),
        .cnt_o      (cnt_w)
    );

    wmb_regfile #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regfile (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_en_i    (clr_en_w),
        .exec_en_i   (exec_en_w),
        .commit_en_i (commit_en_w),
        .merge_or_i  (merge_or_w),
        .pend_i      (pend_w),
        .or_val_i    (or_val_w),
        .last_val_i  (last_val_w),
        .main_we_i   (main_we_i),
        .main_idx_i  (main_idx_i),
        .main_data_i (main_data_i),
        .rd_idx_i    (rd_idx_i),
        .rd_data_o   (rd_data_o)
    );

endmodule

// File: rtl/wmb_checker.sv
module wmb_checker
    import wmb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input wmb_state_e        state,
    input logic              begin_i,
    input logic [CNT_W-1:0]  cnt,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] rd_data
);

    assert_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IDLE && begin_i) |=> state == ST_CAPTURE);

    assert_clear_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_CLEAR) |=> state == ST_EXEC);

    assert_retire_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_COMMIT) |=> (state == ST_IDLE && cnt == '0));

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt <= CNT_W'(DEPTH));

    assert_capture_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_CAPTURE && $stable(rd_idx)) |-> $stable(rd_data));

endmodule

bind write_merge_unit wmb_checker #(
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state   (state_w),
    .begin_i (begin_i),
    .cnt     (cnt_w),
    .rd_idx  (rd_idx_i),
    .rd_data (rd_data_o)
);

// File: tb/tb_write_merge_unit.sv
`timescale 1ns/100ps
module tb_write_merge_unit;

    localparam int NREG = 8;
    localparam int DW   = 16;
    localparam int DEP  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          precise = 1'b0, beg = 1'b0, ops_rd = 1'b0, fin = 1'b0;
    logic          ext_we = 1'b0, main_we = 1'b0;
    logic [2:0]    ext_idx = '0, main_idx = '0, rd_idx = '0;
    logic [DW-1:0] ext_dat = '0, main_dat = '0;
    logic [DW-1:0] rd_dat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [NREG];
    logic [2:0]    e_idx [8];
    logic [DW-1:0] e_dat [8];
    int            n_ext;
    bit            has_main;
    logic [2:0]    m_idx;
    logic [DW-1:0] m_dat;

    always #2 clk = ~clk;

    write_merge_unit dut (
        .clk_i(clk), .rst_ni(rst_n), .precise_i(precise), .begin_i(beg),
        .ops_read_i(ops_rd), .end_i(fin), .ext_we_i(ext_we), .ext_idx_i(ext_idx),
        .ext_data_i(ext_dat), .main_we_i(main_we), .main_idx_i(main_idx),
        .main_data_i(main_dat), .rd_idx_i(rd_idx), .rd_data_o(rd_dat)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] idx, output logic [DW-1:0] v);
        rd_idx = idx;
        #0.1;
        v = rd_dat;
    endtask

    // checks all registers against the model
    task automatic check_all(input string req);
        logic [DW-1:0] v;
        for (int r = 0; r < NREG; r++) begin
            rd(3'(r), v);
            chk(req, v, model[r]);
        end
    endtask

    // one instruction; tag overrides the per-register requirement label
    task automatic run_instr(input bit p, input string tag);
        logic [DW-1:0] nm [NREG];
        logic [DW-1:0] v;
        bit            pend [NREG];
        int            kept;
        string         t;
        kept = (n_ext < DEP) ? n_ext : DEP;
        for (int r = 0; r < NREG; r++) begin nm[r] = model[r]; pend[r] = 1'b0; end
        for (int k = 0; k < kept; k++) pend[e_idx[k]] = 1'b1;
        if (p) begin
            for (int k = 0; k < kept; k++) nm[e_idx[k]] = '0;
            if (has_main) nm[m_idx] = m_dat;
            for (int k = 0; k < kept; k++) nm[e_idx[k]] = nm[e_idx[k]] | e_dat[k];
        end else begin
            if (has_main) nm[m_idx] = m_dat;
            for (int k = 0; k < kept; k++) nm[e_idx[k]] = e_dat[k];
        end

        @(negedge clk);
        beg = 1'b1; precise = p;
        for (int k = 0; k < n_ext; k++) begin
            @(negedge clk);
            beg = 1'b0; precise = ~p;        // R10: late mode change
            ext_we = 1'b1; ext_idx = e_idx[k]; ext_dat = e_dat[k];
            main_we = 1'b1; main_idx = e_idx[k]; main_dat = 16'hBEEF; // R11: stray main write
        end
        @(negedge clk);
        beg = 1'b0; precise = ~p; ext_we = 1'b0; main_we = 1'b0;
        for (int k = 0; k < n_ext; k++) begin
            rd(e_idx[k], v);
            chk("R2", v, model[e_idx[k]]);
        end
        ops_rd = 1'b1;
        @(negedge clk);                      // CLEAR
        ops_rd = 1'b0;
        @(negedge clk);                      // EXEC
        for (int k = 0; k < kept; k++) begin
            rd(e_idx[k], v);
            chk("R6", v, p ? '0 : model[e_idx[k]]);
        end
        main_we = has_main; main_idx = m_idx; main_dat = m_dat;
        ext_we = 1'b1; ext_idx = m_idx + 3'd3; ext_dat = 16'hDEAD; // R11: stray ext write
        @(negedge clk);
        main_we = 1'b0; ext_we = 1'b0; fin = 1'b1;
        @(negedge clk);                      // COMMIT
        fin = 1'b0;
        @(negedge clk);                      // IDLE
        for (int r = 0; r < NREG; r++) begin
            if (tag != "") t = tag;
            else if (pend[r] && has_main && m_idx == 3'(r)) t = p ? "R4" : "R7";
            else if (pend[r]) t = p ? "R5" : "R7";
            else if (has_main && m_idx == 3'(r)) t = "R12";
            else t = "R9";
            rd(3'(r), v);
            chk(t, v, nm[r]);
        end
        for (int r = 0; r < NREG; r++) model[r] = nm[r];
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // preload with main-only instructions
        n_ext = 0; has_main = 1'b1;
        for (int r = 0; r < NREG; r++) begin
            m_idx = 3'(r); m_dat = 16'h1000 + 16'(r * 16'h0123);
            run_instr(r[0], "R12");
        end

        // sweep: every pairing of extension and main destination, both modes
        for (int p = 0; p < 2; p++) begin
            for (int e = 0; e < NREG; e++) begin
                for (int m = 0; m < NREG; m++) begin
                    n_ext = 1; has_main = 1'b1;
                    e_idx[0] = 3'(e);
                    e_dat[0] = 16'h0F0F ^ 16'(e * 16'h1357) ^ 16'(m << 9) ^ 16'(p);
                    m_idx = 3'(m);
                    m_dat = 16'hA5C3 + 16'(e * 16'h0211) + 16'(m * 16'h3001);
                    run_instr(p[0], "");
                end
            end
        end

        // R8: duplicate pending entries
        for (int p = 0; p < 2; p++) begin
            n_ext = 3; has_main = 1'b1;
            e_idx[0] = 3'd2; e_dat[0] = 16'h00F0;
            e_idx[1] = 3'd3; e_dat[1] = 16'h7777;
            e_idx[2] = 3'd2; e_dat[2] = 16'h0F00;
            m_idx = 3'd2; m_dat = 16'h1001;
            run_instr(p[0], "R8");
        end

        // R3: six extension writes, only four recorded
        for (int p = 0; p < 2; p++) begin
            n_ext = 6; has_main = 1'b1;
            for (int k = 0; k < 6; k++) begin
                e_idx[k] = 3'(k); e_dat[k] = 16'h0101 * 16'(k + 1 + p);
            end
            m_idx = 3'd5; m_dat = 16'hC0DE;
            run_instr(p[0], "R3");
        end

        // R11: control pulses and writes in IDLE are ignored
        @(negedge clk);
        ops_rd = 1'b1; fin = 1'b1; main_we = 1'b1; main_idx = 3'd1; main_dat = 16'hFFFF;
        ext_we = 1'b1; ext_idx = 3'd1; ext_dat = 16'hFFFF;
        repeat (2) @(negedge clk);
        ops_rd = 1'b0; fin = 1'b0; main_we = 1'b0; ext_we = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R11");

        // R11: no recorded entry survives into the next instruction
        n_ext = 0; has_main = 1'b0;
        run_instr(1'b1, "R11");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule